// File: doc/BRIEF.md
# Stepped Serial Regulator Divisor Loader

This block programs a core-voltage regulator over a three-wire serial link made of a data line, a shift clock and an active-high load strobe. A host pulses a start input together with a requested core frequency in kHz and a force flag. The block maps the frequency onto a 12-bit divisor code. It then walks the regulator from the code it last loaded toward that target. Each intermediate code goes out as a separate serial frame, and each frame is latched by the strobe before the next one starts. Limiting the size of each move keeps the regulator output from sagging far enough to cut out.

A frame sends twelve bits, most significant first. Every bit has three phases: data set up with the clock low, clock high, and clock low again. After the last bit the strobe goes high for one phase, and the frame closes with one more quiet phase. Each phase lasts a whole number of system clocks, worked out from the clock frequency in MHz and the minimum phase time in microseconds. The block shows when it is busy, gives a one-cycle completion pulse, and always drives the last latched code on an output.

Top module: `vreg_step_loader`

## Requirements
- R1: The target code is 0xFFF for a frequency below 200000 kHz, 0xDE5 for a frequency from 200000 up to and including 299999 kHz, and 0x325 for 300000 kHz or more.
- R2: With force clear, each frame code lies 0x100 above the last latched code when that code is more than 0x100 below the target. It lies 0x100 below when the last latched code is more than 0x100 above the target. In every other case the frame code is the target itself.
- R3: With force set, the first frame of the request carries the target code directly. Any frames after it follow R2.
- R4: Every accepted request sends at least one frame. Frames continue until the latched code equals the target.
- R5: A frame shifts twelve bits, most significant bit first. ser_data_o keeps its value from the start of a bit's setup phase until that bit's final low phase ends, and it is 0 outside bit phases.
- R6: Each bit is made of three phases of PHASE_CYC clocks each (PHASE_CYC = CLK_MHZ*PHASE_US): clock low with data valid, then clock high, then clock low.
- R7: After bit 0, ser_load_o is high for one phase and then low for one more phase. The clock stays low during both. cur_div_o takes the frame's code in the first cycle that the strobe is high.
- R8: busy_o goes high in the cycle after the clock edge that samples start_i while idle. The first frame's first setup phase appears in that same cycle, and each following frame starts right after the previous one with no gap cycles.
- R9: start_i is ignored while busy_o is high. The frames in progress, and the target they converge to, are unchanged.
- R10: In the cycle after the last frame's final phase, busy_o is low and done_o is high. In the cycle after that, done_o is low again.
- R11: After reset, cur_div_o is 0xFFF, ser_data_o, ser_clk_o and ser_load_o are low, and busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| freq_khz_i | input | FREQ_W | Requested core frequency in kHz |
| force_i | input | 1 | Send the target code in the first frame |
| ser_data_o | output | 1 | Serial data to the regulator |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_load_o | output | 1 | Active-high load strobe |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cur_div_o | output | DIV_W | Last latched divisor code |

## Verification
Requests are run that ramp down over three frames, ramp down over eleven frames and ramp up over thirteen frames. These separate the upward and downward stepping rules and exercise the final short step in each direction. Forced requests that jump straight across the whole range show that force skips the stepping. A forced request whose target equals the current code shows that one frame is still sent when no move is needed. Frequencies placed exactly on and just below each threshold check the code boundaries. A start pulse with a different frequency, given in the middle of a ramp, must leave every following cycle of the waveform unchanged.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HIGH  = 3'd2,
    PH_FALL  = 3'd3,
    PH_LATCH = 3'd4,
    PH_QUIET = 3'd5
  } wire_phase_e;

  typedef enum logic {
    CT_IDLE = 1'b0,
    CT_RUN  = 1'b1
  } ctrl_state_e;

endpackage

// File: rtl/vstep_code_sel.sv
module vstep_code_sel #(
  parameter int FREQ_W    = 20,
  parameter int DIV_W     = 12,
  parameter int LOW_KHZ   = 200000,
  parameter int MID_KHZ   = 300000,
  parameter int CODE_SLOW = 'hFFF,
  parameter int CODE_MID  = 'hDE5,
  parameter int CODE_FAST = 'h325
) (
  input  logic [FREQ_W-1:0] freq_khz_i,
  output logic [DIV_W-1:0]  code_o
);
  localparam logic [FREQ_W-1:0] LOW_T = FREQ_W'(LOW_KHZ);
  localparam logic [FREQ_W-1:0] MID_T = FREQ_W'(MID_KHZ);

  always_comb begin
    if (freq_khz_i < LOW_T)      code_o = DIV_W'(CODE_SLOW);
    else if (freq_khz_i < MID_T) code_o = DIV_W'(CODE_MID);
    else                         code_o = DIV_W'(CODE_FAST);
  end
endmodule

// File: rtl/vstep_step_plan.sv
module vstep_step_plan #(
  parameter int DIV_W = 12,
  parameter int STEP  = 'h100
) (
  input  logic [DIV_W-1:0] cur_i,
  input  logic [DIV_W-1:0] target_i,
  output logic [DIV_W-1:0] next_o
);
  localparam int EW = DIV_W + 2;
  localparam logic [EW-1:0] STEP_E = EW'(STEP);

  logic [EW-1:0] cur_e, tgt_e, up_e, dn_e;

  always_comb begin
    cur_e = EW'(cur_i);
    tgt_e = EW'(target_i);
    up_e  = cur_e + STEP_E;
    dn_e  = cur_e - STEP_E;
    if (up_e < tgt_e)                next_o = up_e[DIV_W-1:0];
    else if (cur_e > tgt_e + STEP_E) next_o = dn_e[DIV_W-1:0];
    else                             next_o = target_i;
  end
endmodule

// File: rtl/vstep_frame_shifter.sv
module vstep_frame_shifter
  import vstep_pkg::*;
#(
  parameter int DIV_W     = 12,
  parameter int PHASE_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] code_i,
  output logic [DIV_W-1:0] word_o,
  output logic             latch_go_o,
  output logic             frame_end_o,
  output logic             ser_data_o,
  output logic             ser_clk_o,
  output logic             ser_load_o
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int BW = (DIV_W > 1) ? $clog2(DIV_W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);
  localparam logic [BW-1:0] BIT_TOP  = BW'(DIV_W - 1);

  wire_phase_e      ph_q, ph_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [DIV_W-1:0] sh_q, sh_d;
  logic [DIV_W-1:0] word_q, word_d;
  logic             phase_last;

  assign phase_last = (cnt_q == CNT_LAST);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    word_d = word_q;
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_d   = PH_SETUP;
        cnt_d  = '0;
        bit_d  = BIT_TOP;
        sh_d   = code_i;
        word_d = code_i;
      end
    end else if (!phase_last) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
      unique case (ph_q)
        PH_SETUP: ph_d = PH_HIGH;
        PH_HIGH:  ph_d = PH_FALL;
        PH_FALL: begin
          if (bit_q == '0) begin
            ph_d = PH_LATCH;
          end else begin
            ph_d  = PH_SETUP;
            bit_d = bit_q - 1'b1;
            sh_d  = {sh_q[DIV_W-2:0], 1'b0};
          end
        end
        PH_LATCH: ph_d = PH_QUIET;
        PH_QUIET: begin
          if (start_i) begin
            ph_d   = PH_SETUP;
            bit_d  = BIT_TOP;
            sh_d   = code_i;
            word_d = code_i;
          end else begin
            ph_d = PH_IDLE;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      word_q <= word_d;
    end
  end

  assign word_o      = word_q;
  assign latch_go_o  = (ph_q == PH_FALL) && (bit_q == '0) && phase_last;
  assign frame_end_o = (ph_q == PH_QUIET) && phase_last;
  assign ser_clk_o   = (ph_q == PH_HIGH);
  assign ser_load_o  = (ph_q == PH_LATCH);
  assign ser_data_o  = ((ph_q == PH_SETUP) || (ph_q == PH_HIGH) || (ph_q == PH_FALL))
                       ? sh_q[DIV_W-1] : 1'b0;

  assert_clk_load_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk_o && ser_load_o));

  assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_o |-> $stable(ser_data_o));

  assert_phase_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  assert_load_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load_o) |-> (ph_q == PH_QUIET));
endmodule

// File: rtl/vreg_step_loader.sv
module vreg_step_loader
  import vstep_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int PHASE_US  = 1,
  parameter int FREQ_W    = 20,
  parameter int DIV_W     = 12,
  parameter int STEP      = 'h100,
  parameter int LOW_KHZ   = 200000,
  parameter int MID_KHZ   = 300000,
  parameter int CODE_SLOW = 'hFFF,
  parameter int CODE_MID  = 'hDE5,
  parameter int CODE_FAST = 'h325
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_khz_i,
  input  logic              force_i,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              ser_load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DIV_W-1:0]  cur_div_o
);
  localparam int PHASE_CYC = CLK_MHZ * PHASE_US;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  ctrl_state_e      st_q, st_d;
  logic [DIV_W-1:0] target_q, target_d;
  logic [DIV_W-1:0] cur_q, cur_d;
  logic             done_q, done_d;
  logic             forced_q, forced_d;

  logic [DIV_W-1:0] sel_code, plan_src, plan_tgt, plan_code, sh_code, sh_word;
  logic             sh_start, latch_go, frame_end;
  logic             accept, chain;

  vstep_code_sel #(
    .FREQ_W(FREQ_W), .DIV_W(DIV_W), .LOW_KHZ(LOW_KHZ), .MID_KHZ(MID_KHZ),
    .CODE_SLOW(CODE_SLOW), .CODE_MID(CODE_MID), .CODE_FAST(CODE_FAST)
  ) u_sel (
    .freq_khz_i (freq_khz_i),
    .code_o     (sel_code)
  );

  assign plan_src = cur_q;
  assign plan_tgt = (st_q == CT_IDLE) ? sel_code : target_q;

  vstep_step_plan #(.DIV_W(DIV_W), .STEP(STEP)) u_plan (
    .cur_i    (plan_src),
    .target_i (plan_tgt),
    .next_o   (plan_code)
  );

  assign accept   = (st_q == CT_IDLE) && start_i;
  assign chain    = (st_q == CT_RUN) && frame_end && (cur_q != target_q);
  assign sh_start = accept || chain;
  assign sh_code  = (accept && force_i) ? sel_code : plan_code;

  vstep_frame_shifter #(.DIV_W(DIV_W), .PHASE_CYC(PHASE_CYC)) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (sh_start),
    .code_i      (sh_code),
    .word_o      (sh_word),
    .latch_go_o  (latch_go),
    .frame_end_o (frame_end),
    .ser_data_o  (ser_data_o),
    .ser_clk_o   (ser_clk_o),
    .ser_load_o  (ser_load_o)
  );

  always_comb begin
    st_d     = st_q;
    target_d = target_q;
    cur_d    = cur_q;
    done_d   = 1'b0;
    forced_d = forced_q;
    if (latch_go) cur_d = sh_word;
    if (accept) begin
      st_d     = CT_RUN;
      target_d = sel_code;
      forced_d = force_i;
    end else if (chain) begin
      forced_d = 1'b0;
    end else if ((st_q == CT_RUN) && frame_end) begin
      st_d   = CT_IDLE;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= CT_IDLE;
      target_q <= DIV_W'(CODE_SLOW);
      cur_q    <= DIV_W'(CODE_SLOW);
      done_q   <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      target_q <= target_d;
      cur_q    <= cur_d;
      done_q   <= done_d;
      forced_q <= forced_d;
    end
  end

  assign busy_o    = (st_q == CT_RUN);
  assign done_o    = done_q;
  assign cur_div_o = cur_q;

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !busy_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

  assert_target_held_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && $past(busy_o)) |-> $stable(target_q));

  assert_bounded_move_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$stable(cur_q) && !forced_q) |->
      ((int'(cur_q) - int'($past(cur_q)) <= STEP) &&
       (int'($past(cur_q)) - int'(cur_q) <= STEP)));

  assert_done_on_target_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (cur_q == target_q));
endmodule

// File: tb/vreg_step_loader_bench.sv
`timescale 1ns/1ps
module vreg_step_loader_bench;
  localparam int CLK_MHZ  = 4;
  localparam int PHASE_US = 1;
  localparam int P        = CLK_MHZ * PHASE_US;
  localparam int FREQ_W   = 20;
  localparam int DIV_W    = 12;
  localparam int FRAME    = (3 * DIV_W + 2) * P;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [FREQ_W-1:0] freq_khz_i;
  logic force_i;
  logic ser_data_o, ser_clk_o, ser_load_o, busy_o, done_o;
  logic [DIV_W-1:0] cur_div_o;

  always #2.5 clk = ~clk;

  vreg_step_loader #(.CLK_MHZ(CLK_MHZ), .PHASE_US(PHASE_US),
                     .FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_vreg_step_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_khz_i(freq_khz_i),
    .force_i(force_i), .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o),
    .ser_load_o(ser_load_o), .busy_o(busy_o), .done_o(done_o),
    .cur_div_o(cur_div_o)
  );

  int checks = 0;
  int fails  = 0;
  int model_cur = 'hFFF;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick_code(input int khz);
    if (khz < 200000)      return 'hFFF;
    else if (khz < 300000) return 'hDE5;
    else                   return 'h325;
  endfunction

  function automatic int step_toward(input int c, input int t);
    if (c < t - 'h100)      return c + 'h100;
    else if (c > t + 'h100) return c - 'h100;
    else                    return t;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " data"}, int'(ser_data_o), 0);
    chk({tag, " clk"},  int'(ser_clk_o), 0);
    chk({tag, " load"}, int'(ser_load_o), 0);
    chk({tag, " busy"}, int'(busy_o), 0);
  endtask

  // drives one request and compares every following cycle with the model
  task automatic run_req(input int khz, input bit frc, input bit poke, input string tag);
    int tgt;
    int frames[$];
    int c;
    bit first;
    tgt = pick_code(khz);
    c = model_cur;
    first = 1'b1;
    do begin
      int s;
      s = (first && frc) ? tgt : step_toward(c, tgt);
      frames.push_back(s);
      c = s;
      first = 1'b0;
    end while (c != tgt);

    @(negedge clk);
    start_i = 1'b1; freq_khz_i = FREQ_W'(khz); force_i = frc;
    @(posedge clk);
    foreach (frames[f]) begin
      for (int cyc = 0; cyc < FRAME; cyc++) begin
        int ph, exp_d, exp_c, exp_l, w;
        @(negedge clk);
        start_i = 1'b0;
        w = frames[f];
        ph = cyc / P;
        exp_d = 0; exp_c = 0; exp_l = 0;
        if (ph < 3 * DIV_W) begin
          exp_d = (w >> (DIV_W - 1 - ph / 3)) & 1;
          exp_c = ((ph % 3) == 1) ? 1 : 0;
        end else if (ph == 3 * DIV_W) begin
          exp_l = 1;
        end
        if (ph >= 3 * DIV_W) model_cur = w;
        chk("R5 data", int'(ser_data_o), exp_d);
        chk("R6 clk",  int'(ser_clk_o), exp_c);
        chk("R7 load", int'(ser_load_o), exp_l);
        chk({tag, " cur"}, int'(cur_div_o), model_cur);
        chk("R8 busy", int'(busy_o), 1);
        chk("R10 done low while busy", int'(done_o), 0);
        if (poke && f == 0 && cyc == 10) begin
          // R9: a request during busy must change nothing
          start_i = 1'b1; freq_khz_i = FREQ_W'(150000); force_i = 1'b1;
        end
      end
    end
    @(negedge clk);
    chk("R10 done", int'(done_o), 1);
    chk("R1 final code", int'(cur_div_o), tgt);
    chk("R4 frame count", int'(busy_o), 0);
    check_idle("R10 end");
    @(negedge clk);
    chk("R10 done pulse width", int'(done_o), 0);
    check_idle("R10 after");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    freq_khz_i = '0;
    force_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 cur", int'(cur_div_o), 'hFFF);
    chk("R11 data", int'(ser_data_o), 0);
    chk("R11 clk", int'(ser_clk_o), 0);
    chk("R11 load", int'(ser_load_o), 0);
    chk("R11 busy", int'(busy_o), 0);
    chk("R11 done", int'(done_o), 0);

    run_req(250000, 1'b0, 1'b1, "R2 down3 R9");
    run_req(400000, 1'b0, 1'b0, "R2 down11");
    run_req(199999, 1'b0, 1'b0, "R2 up13");
    run_req(300000, 1'b1, 1'b0, "R3 force jump");
    run_req(200000, 1'b0, 1'b0, "R1 boundary");
    run_req(299999, 1'b1, 1'b0, "R4 same code");
    run_req(150000, 1'b1, 1'b0, "R3 force up");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule